// File: doc/BRIEF.md
# LPC Firmware Memory Cycle Target

This block is the target side of a firmware-memory cycle on a low-pin-count bus. It watches a clock, an active-low reset, an active-low frame strobe and a 4-bit multiplexed address/data bus. It recognises a read or write start code and checks the cycle's ID nibble against four strap inputs. It then collects the address and the transfer size. A read returns up to 128 bytes in one frame. A write accepts up to 4 bytes. Bus turnaround and sync phases follow the cycle's fixed order.

The storage behind the block is an external synchronous byte memory. A read request returns its data on the following cycle. A write completes at once, and the memory then raises a busy flag for some time. The block turns that busy flag and its own write strobes into a status bit that the host can poll for end of write. Reads issued while a write is still settling answer with wait syncs until the memory is free. The behaviour is counted in clocks only, so the same logic serves a 33 MHz or a 66 MHz bus.

The controller has nine named states: IDLE, ID, ADDR, SIZE, WDATA, TAR_IN, SYNC, RDATA and TAR_OUT.
- With frame low, a valid start code moves any state to ID, and any other value moves it to IDLE.
- ID moves to ADDR on an ID match, and otherwise back to IDLE.
- ADDR moves to SIZE after seven nibbles.
- SIZE moves to IDLE on a size the direction does not allow, to WDATA for a write and to TAR_IN for a read.
- WDATA moves to TAR_IN after the last high nibble, and TAR_IN moves to SYNC after two clocks.
- SYNC moves to TAR_OUT for a write. For a read it moves to RDATA once the first byte is ready.
- RDATA moves to TAR_OUT after the last high nibble, and TAR_OUT moves to IDLE after two clocks.

Top module: `fwmem_target`

## Requirements
- R1: While `frame_n` is low, `lad_in` = 4'b1101 starts a read and 4'b1110 starts a write. Any other value gets no response: `lad_oe` and `mem_we` stay low.
- R2: The nibble after the start must equal `id_strap`. On a mismatch the cycle is ignored: no bus drive and no memory write.
- R3: Seven address nibbles follow, most significant first. Only the low `ADDR_W` bits of the resulting 28-bit value select the byte.
- R4: The size nibble encodes the byte count: 0 is 1 byte, 1 is 2, 2 is 4, 4 is 16 and 7 is 128. Reads accept all five. Any other code gets no response.
- R5: Writes accept only size codes 0, 1 and 2. A write with any other code gets no response and writes nothing.
- R6: The read response is fixed:
  - two clocks with the bus released;
  - one or more 4'b0101 wait syncs;
  - one 4'b0000 ready sync;
  - each byte, low nibble first;
  - one clock of 4'b1111 driven;
  - the bus released.
  With the memory free, exactly one wait sync appears.
- R7: A write takes its data nibbles low nibble first. The response is two released clocks, one 4'b0000 sync, one driven 4'b1111 clock, then release. Each byte reaches the memory.
- R8: A transfer stays inside the window aligned to its size. The byte address increments in the low bits and wraps to the window start. The upper bits do not change.
- R9: A read does not fetch while a write is pending or the memory is busy. It sends wait syncs until the memory is free.
- R10: `write_idle` is low from the cycle of a memory write until `mem_busy` has dropped. `mem_busy` must rise the cycle after the write. `write_idle` is high after reset.
- R11: Frame going low during a cycle aborts it: the bus is released on the next cycle. Reset forces IDLE with the bus released and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Active-low cycle framing strobe |
| lad_in | input | 4 | Address/data nibble from the bus |
| lad_out | output | 4 | Nibble driven by the target |
| lad_oe | output | 1 | Target drives the bus when high |
| id_strap | input | 4 | Device select straps |
| mem_rd | output | 1 | Byte read request, data valid next cycle |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | ADDR_W | Byte address for read or write |
| mem_wdata | output | 8 | Write data byte |
| mem_rdata | input | 8 | Read data byte |
| mem_busy | input | 1 | Memory still completing a write |
| write_idle | output | 1 | End-of-write status, high when writes are complete |

## Verification
The bench builds the block with `ADDR_W` = 12 behind a 4 KiB stub. This lets a 128-byte read cover a full window. It also means the upper bits of the 28-bit address field must drop out, because the test addresses carry non-zero upper nibbles. The stub holds busy for 20 cycles after each write. That is long enough for a read issued straight after a write to meet wait syncs, and for the end-of-write status to be seen low well after the write frame has closed.

// File: rtl/fwmem_pkg.sv
package fwmem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ADDR,
        ST_SIZE,
        ST_WDATA,
        ST_TAR_IN,
        ST_SYNC,
        ST_RDATA,
        ST_TAR_OUT
    } fw_state_e;

    localparam logic [3:0] CODE_RD_START = 4'b1101;
    localparam logic [3:0] CODE_WR_START = 4'b1110;
    localparam logic [3:0] CODE_SYNC_WAIT = 4'b0101;
    localparam logic [3:0] CODE_SYNC_OK = 4'b0000;
    localparam logic [3:0] CODE_TAR = 4'b1111;

    localparam int ADDR_NIBS = 7;
    localparam int TAR_CYCLES = 2;
    localparam int BYTE_CNT_W = 8;
    localparam int WIN_W = 7;

endpackage

// File: rtl/fwmem_size_dec.sv
module fwmem_size_dec
    import fwmem_pkg::*;
(
    input  logic [3:0]            code,
    input  logic                  is_write,
    output logic                  valid,
    output logic [BYTE_CNT_W-1:0] bytes,
    output logic [WIN_W-1:0]      mask
);

    always_comb begin
        valid = 1'b1;
        case (code)
            4'd0:    bytes = 8'd1;
            4'd1:    bytes = 8'd2;
            4'd2:    bytes = 8'd4;
            4'd4:    bytes = 8'd16;
            4'd7:    bytes = 8'd128;
            default: begin
                bytes = 8'd1;
                valid = 1'b0;
            end
        endcase
        // writes are limited to the three short sizes
        if (is_write && (bytes > 8'd4)) begin
            valid = 1'b0;
        end
        // a 128-byte window wraps to an all-ones 7-bit mask
        mask = bytes[WIN_W-1:0] - 7'd1;
    end

    always_comb begin
        assert_wr_size_limit_R5: assert (!(is_write && valid) || (bytes <= 8'd4));
        assert_size_onehot_R4: assert (!valid || $onehot(bytes));
    end

endmodule

// File: rtl/fwmem_addr_gen.sv
module fwmem_addr_gen
    import fwmem_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WIN_W-1:0]  load_mask,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    localparam int PAD_W = ADDR_W - WIN_W;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] mask_q;
    logic [ADDR_W-1:0] mask_ext;

    assign mask_ext = {{PAD_W{1'b0}}, load_mask};
    assign addr = addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            mask_q <= mask_ext;
        end else if (step) begin
            // increment inside the aligned window, keep the upper bits
            addr_q <= (addr_q & ~mask_q) | ((addr_q + 1'b1) & mask_q);
        end
    end

    assert_window_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> ((addr_q & ~mask_q) == $past(addr_q & ~mask_q)));

endmodule

// File: rtl/fwmem_wr_status.sv
module fwmem_wr_status (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_pulse,
    input  logic busy_in,
    output logic idle_out
);

    logic pend_q;

    // covers the gap until the memory raises its busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= wr_pulse;
        end
    end

    assign idle_out = !(wr_pulse || pend_q || busy_in);

    assert_idle_low_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !idle_out);

endmodule

// File: rtl/fwmem_target.sv
module fwmem_target
    import fwmem_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [3:0]        lad_in,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic [3:0]        id_strap,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_busy,
    output logic              write_idle
);

    localparam int CNT_W = 3;
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
    localparam logic [CNT_W-1:0] TAR_LAST = CNT_W'(TAR_CYCLES - 1);

    fw_state_e             state_q;
    logic                  dir_wr_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [ADDR_W-1:0]     addr_sr_q;
    logic [BYTE_CNT_W-1:0] bytes_left_q;
    logic                  hi_q;
    logic [3:0]            lo_q;
    logic [7:0]            byte_q;
    logic                  rd_pend_q;

    logic                  sz_ok;
    logic [BYTE_CNT_W-1:0] sz_bytes;
    logic [WIN_W-1:0]      sz_mask;
    logic                  addr_load;

    fwmem_size_dec u_size (
        .code     (lad_in),
        .is_write (dir_wr_q),
        .valid    (sz_ok),
        .bytes    (sz_bytes),
        .mask     (sz_mask)
    );

    assign addr_load = (state_q == ST_SIZE) && frame_n;

    fwmem_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_load),
        .load_addr (addr_sr_q),
        .load_mask (sz_mask),
        .step      (mem_rd || mem_we),
        .addr      (mem_addr)
    );

    fwmem_wr_status u_wstat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_pulse (mem_we),
        .busy_in  (mem_busy),
        .idle_out (write_idle)
    );

    // read data pipeline: a request issued this cycle lands in byte_q next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            byte_q    <= '0;
        end else begin
            rd_pend_q <= mem_rd;
            if (rd_pend_q) begin
                byte_q <= mem_rdata;
            end
        end
    end

    // state register and cycle counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            dir_wr_q     <= 1'b0;
            cnt_q        <= '0;
            addr_sr_q    <= '0;
            bytes_left_q <= '0;
            hi_q         <= 1'b0;
            lo_q         <= '0;
        end else if (!frame_n) begin
            // frame low: new start code or abort
            if ((lad_in == CODE_RD_START) || (lad_in == CODE_WR_START)) begin
                state_q <= ST_ID;
            end else begin
                state_q <= ST_IDLE;
            end
            dir_wr_q <= (lad_in == CODE_WR_START);
            cnt_q    <= '0;
            hi_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                end
                ST_ID: begin
                    cnt_q   <= '0;
                    state_q <= (lad_in == id_strap) ? ST_ADDR : ST_IDLE;
                end
                ST_ADDR: begin
                    addr_sr_q <= {addr_sr_q[ADDR_W-5:0], lad_in};
                    cnt_q     <= cnt_q + 1'b1;
                    if (cnt_q == ADDR_LAST) begin
                        state_q <= ST_SIZE;
                    end
                end
                ST_SIZE: begin
                    cnt_q <= '0;
                    hi_q  <= 1'b0;
                    if (!sz_ok) begin
                        state_q <= ST_IDLE;
                    end else begin
                        bytes_left_q <= sz_bytes;
                        state_q      <= dir_wr_q ? ST_WDATA : ST_TAR_IN;
                    end
                end
                ST_WDATA: begin
                    if (!hi_q) begin
                        lo_q <= lad_in;
                        hi_q <= 1'b1;
                    end else begin
                        hi_q         <= 1'b0;
                        bytes_left_q <= bytes_left_q - 1'b1;
                        if (bytes_left_q == 8'd1) begin
                            state_q <= ST_TAR_IN;
                        end
                    end
                end
                ST_TAR_IN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == TAR_LAST) begin
                        cnt_q   <= '0;
                        state_q <= ST_SYNC;
                    end
                end
                ST_SYNC: begin
                    cnt_q <= '0;
                    hi_q  <= 1'b0;
                    if (dir_wr_q) begin
                        state_q <= ST_TAR_OUT;
                    end else if (rd_pend_q) begin
                        state_q <= ST_RDATA;
                    end
                end
                ST_RDATA: begin
                    if (!hi_q) begin
                        hi_q <= 1'b1;
                    end else begin
                        hi_q         <= 1'b0;
                        bytes_left_q <= bytes_left_q - 1'b1;
                        if (bytes_left_q == 8'd1) begin
                            cnt_q   <= '0;
                            state_q <= ST_TAR_OUT;
                        end
                    end
                end
                ST_TAR_OUT: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == TAR_LAST) begin
                        cnt_q   <= '0;
                        state_q <= ST_IDLE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        lad_oe    = 1'b0;
        lad_out   = CODE_TAR;
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = {lad_in, lo_q};
        unique case (state_q)
            ST_WDATA: begin
                mem_we = hi_q && frame_n;
            end
            ST_SYNC: begin
                lad_oe = 1'b1;
                if (dir_wr_q || rd_pend_q) begin
                    lad_out = CODE_SYNC_OK;
                end else begin
                    lad_out = CODE_SYNC_WAIT;
                    mem_rd  = frame_n && write_idle;
                end
            end
            ST_RDATA: begin
                lad_oe  = 1'b1;
                lad_out = hi_q ? byte_q[7:4] : byte_q[3:0];
                // prefetch the next byte while the low nibble is on the bus
                mem_rd  = !hi_q && (bytes_left_q != 8'd1) && frame_n;
            end
            ST_TAR_OUT: begin
                lad_oe  = (cnt_q == '0);
                lad_out = CODE_TAR;
            end
            default: begin
                lad_oe = 1'b0;
            end
        endcase
    end

    assert_abort_releases_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> (!lad_oe && !mem_we));

    assert_id_mismatch_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ID && frame_n && lad_in != id_strap) |=> (state_q == ST_IDLE));

    assert_no_fetch_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !mem_busy);

    assert_ready_then_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC && !dir_wr_q && lad_oe && lad_out == CODE_SYNC_OK && frame_n)
        |=> (state_q == ST_RDATA && lad_oe));

    assert_rd_wr_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we));

    assert_released_in_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SIZE && frame_n && sz_ok && !dir_wr_q) |=> !lad_oe);

endmodule

// File: tb/tb_fwmem_target.sv
module tb_fwmem_target;

    localparam int AW = 12;
    localparam int MEM_N = 1 << AW;
    localparam int BUSY_CYC = 20;
    localparam logic [3:0] MY_ID = 4'hA;
    localparam logic [3:0] ST_RD = 4'b1101;
    localparam logic [3:0] ST_WR = 4'b1110;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          frame_n;
    logic [3:0]    lad_in;
    logic [3:0]    lad_out;
    logic          lad_oe;
    logic [3:0]    id_strap;
    logic          mem_rd;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          mem_busy;
    logic          write_idle;

    always #5 clk = ~clk;

    fwmem_target #(.ADDR_W(AW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .lad_in     (lad_in),
        .lad_out    (lad_out),
        .lad_oe     (lad_oe),
        .id_strap   (id_strap),
        .mem_rd     (mem_rd),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_busy   (mem_busy),
        .write_idle (write_idle)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    // stub array: one-cycle read latency, busy for BUSY_CYC cycles after a write
    logic [7:0] stub [0:MEM_N-1];
    int busy_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_N; i++) stub[i] <= pat(i);
            busy_cnt  <= 0;
            mem_rdata <= '0;
        end else begin
            if (mem_rd) mem_rdata <= stub[mem_addr];
            if (mem_we) begin
                stub[mem_addr] <= mem_wdata;
                busy_cnt       <= BUSY_CYC;
            end else if (busy_cnt != 0) begin
                busy_cnt <= busy_cnt - 1;
            end
        end
    end
    assign mem_busy = (busy_cnt != 0);

    logic [7:0] model [0:MEM_N-1];
    int n_chk = 0;
    int n_fail = 0;
    int act_cnt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // one host clock; activity is sampled before the new drive
    task automatic nib(input logic fr, input logic [3:0] v);
        @(negedge clk);
        if (lad_oe || mem_we) act_cnt++;
        frame_n = fr;
        lad_in  = v;
    endtask

    task automatic header(input logic [3:0] st, input logic [3:0] id, input logic [27:0] a,
                          input logic [3:0] sz);
        nib(1'b0, st);
        nib(1'b1, id);
        for (int i = 6; i >= 0; i--) nib(1'b1, a[4*i +: 4]);
        nib(1'b1, sz);
    endtask

    function automatic int win(input int base, input int mask, input int i);
        return ((base & ~mask) | ((base + i) & mask)) & (MEM_N - 1);
    endfunction

    // target response after the last host nibble; nbytes = 0 for a write
    task automatic resp(input int nbytes, input int base, output int waits, output int bad);
        bad = 0;
        waits = 0;
        repeat (2) begin
            @(negedge clk);
            frame_n = 1'b1;
            lad_in = 4'hF;
            if (lad_oe) bad++;
        end
        @(negedge clk);
        while (lad_oe && lad_out == 4'b0101 && waits < 100) begin
            waits++;
            @(negedge clk);
        end
        if (!(lad_oe && lad_out == 4'b0000)) bad++;
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] got;
            @(negedge clk);
            got[3:0] = lad_out;
            if (!lad_oe) bad++;
            @(negedge clk);
            got[7:4] = lad_out;
            if (!lad_oe) bad++;
            if (got != model[win(base, nbytes - 1, b)]) bad++;
        end
        @(negedge clk);
        if (!(lad_oe && lad_out == 4'hF)) bad++;
        @(negedge clk);
        if (lad_oe) bad++;
    endtask

    task automatic do_read(input logic [27:0] a, input logic [3:0] sz, input int nbytes,
                           input string req, output int waits);
        int bad;
        header(ST_RD, MY_ID, a, sz);
        resp(nbytes, int'(a[AW-1:0]), waits, bad);
        chk(bad == 0 && waits >= 1, req, bad, 0, "read frame errors");
    endtask

    task automatic do_write(input logic [27:0] a, input logic [3:0] sz, input int nbytes,
                            input logic [31:0] d, input string req);
        int bad;
        int waits;
        header(ST_WR, MY_ID, a, sz);
        for (int i = 0; i < nbytes; i++) begin
            nib(1'b1, d[8*i +: 4]);
            nib(1'b1, d[8*i+4 +: 4]);
            model[win(int'(a[AW-1:0]), nbytes - 1, i)] = d[8*i +: 8];
        end
        resp(0, 0, waits, bad);
        chk(bad == 0 && waits == 0, req, bad, 0, "write frame errors");
    endtask

    task automatic quiet(input int n);
        repeat (n) nib(1'b1, 4'hF);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!lad_oe && !mem_rd && !mem_we, "R11", int'(lad_oe), 0, "bus idle in reset");
        chk(write_idle == 1'b1, "R10", int'(write_idle), 1, "status after reset");
    endtask

    task automatic t_read_sizes();
        int w;
        do_read(28'hABC_D100, 4'd0, 1, "R4", w);
        chk(w == 1, "R6", w, 1, "single wait sync when free");
        do_read(28'h123_4102, 4'd1, 2, "R3", w);
        do_read(28'hFFF_F204, 4'd2, 4, "R6", w);
        do_read(28'h000_0310, 4'd4, 16, "R4", w);
        do_read(28'h555_5780, 4'd7, 128, "R4", w);
    endtask

    task automatic t_writes();
        int w;
        do_write(28'h000_0010, 4'd0, 1, 32'h0000_00E1, "R7");
        do_write(28'h0F0_0020, 4'd1, 2, 32'h0000_B2C3, "R7");
        do_write(28'h000_0040, 4'd2, 4, 32'h1234_5678, "R7");
        do_read(28'h000_0010, 4'd0, 1, "R7", w);
        do_read(28'h000_0020, 4'd1, 2, "R7", w);
        do_read(28'h000_0040, 4'd2, 4, "R7", w);
    endtask

    task automatic t_wrap();
        int w;
        do_read(28'h0FF_F0A2, 4'd2, 4, "R8", w);
        do_write(28'h000_0151, 4'd1, 2, 32'h0000_5AC3, "R8");
        do_read(28'h000_0150, 4'd1, 2, "R8", w);
    endtask

    task automatic t_ignored();
        int s;
        s = act_cnt;
        header(ST_RD, 4'h5, 28'h000_0100, 4'd0);
        quiet(20);
        chk(act_cnt == s, "R2", act_cnt - s, 0, "read with foreign id");
        s = act_cnt;
        header(ST_WR, 4'h5, 28'h000_0100, 4'd0);
        nib(1'b1, 4'h3);
        nib(1'b1, 4'h4);
        quiet(20);
        chk(act_cnt == s, "R2", act_cnt - s, 0, "write with foreign id");
        s = act_cnt;
        header(4'h0, MY_ID, 28'h000_0100, 4'd0);
        quiet(20);
        chk(act_cnt == s, "R1", act_cnt - s, 0, "start code 0000");
        s = act_cnt;
        header(4'hC, MY_ID, 28'h000_0100, 4'd0);
        quiet(20);
        chk(act_cnt == s, "R1", act_cnt - s, 0, "start code 1100");
        s = act_cnt;
        header(ST_RD, MY_ID, 28'h000_0100, 4'd3);
        quiet(20);
        chk(act_cnt == s, "R4", act_cnt - s, 0, "read size code 3");
        s = act_cnt;
        header(ST_WR, MY_ID, 28'h000_0100, 4'd4);
        for (int i = 0; i < 8; i++) nib(1'b1, 4'(i));
        quiet(20);
        chk(act_cnt == s, "R5", act_cnt - s, 0, "write size code 4");
    endtask

    task automatic t_busy();
        int w;
        int k;
        do_write(28'h000_0200, 4'd0, 1, 32'h0000_0077, "R10");
        chk(write_idle == 1'b0, "R10", int'(write_idle), 0, "status right after write");
        k = 0;
        while (!write_idle && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk(k >= 10 && k < 40 && !mem_busy, "R10", k, 15, "cycles until end of write");
        do_write(28'h000_0201, 4'd0, 1, 32'h0000_0099, "R9");
        do_read(28'h000_0200, 4'd1, 2, "R9", w);
        chk(w >= 2, "R9", w, 4, "wait syncs during busy");
    endtask

    task automatic t_abort();
        int g;
        int s;
        int w;
        header(ST_RD, MY_ID, 28'h000_0300, 4'd4);
        repeat (2) begin
            @(negedge clk);
            lad_in = 4'hF;
        end
        g = 0;
        @(negedge clk);
        while (!(lad_oe && lad_out == 4'b0000) && g < 50) begin
            g++;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        frame_n = 1'b0;
        lad_in  = 4'hF;
        @(negedge clk);
        frame_n = 1'b1;
        chk(!lad_oe, "R11", int'(lad_oe), 0, "bus released after abort");
        s = act_cnt;
        quiet(20);
        chk(act_cnt == s, "R11", act_cnt - s, 0, "quiet after abort");
        do_read(28'h000_0300, 4'd2, 4, "R11", w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        frame_n  = 1'b1;
        lad_in   = 4'hF;
        id_strap = MY_ID;
        for (int i = 0; i < MEM_N; i++) model[i] = pat(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        chk(!lad_oe && write_idle, "R11", int'(lad_oe), 0, "idle after reset release");
        t_read_sizes();
        t_writes();
        t_wrap();
        t_ignored();
        t_busy();
        t_abort();
        quiet(5);
        finish_run();
    end

endmodule